// File: doc/BRIEF.md
# Three-wire potentiometer wiper controller

This block is the digital core of a 100-position digital potentiometer. Three asynchronous control lines drive it. The first is an active-low select (`sel_n`). The second is a direction line (`dir_up`). The third is an increment strobe (`step`). All three are brought into the system clock through two-flop synchronisers. Edges are then detected on the synchronised copies.

While the block is selected, each falling edge of the strobe moves a 7-bit wiper position by one tap, either up or down. The position saturates at both ends. The position is decoded into a one-hot tap-select bus that drives the transfer gates of the resistor array.

A register stands in for the nonvolatile cell. It captures the wiper when select is released while the strobe is high. Releasing select with the strobe low leaves the register untouched.

A power-on reset (`rst_n`) models a power cycle. During that reset the saved value is copied back into the wiper. A value above the top tap is clamped to the top tap on the way back.

A separate initialisation input (`nv_clear_n`) models factory-fresh storage. It loads the register with a parameterised default, which is mid-scale by default.

A store keeps a busy flag high for a parameterised number of clocks. While busy is high, strobe and select edges are ignored.

Top module: `wiper_ctrl`

## Requirements
- R1: After `nv_clear_n` and then `rst_n` are released, `wiper` equals DEFAULT_POS (49) and `busy` is 0.
- R2: With select low and `dir_up` high, each falling edge of `step` raises `wiper` by exactly 1, three clocks after the edge reaches the pin.
- R3: With select low and `dir_up` low, each falling edge of `step` lowers `wiper` by exactly 1.
- R4: `wiper` never leaves 0..99. A step up at 99 leaves it at 99, and a step down at 0 leaves it at 0.
- R5: While `sel_n` is high, edges on `step` and changes on `dir_up` leave `wiper` unchanged.
- R6: `tap_sel` is one-hot, with bit index equal to `wiper`. Bit 0 is the low terminal and bit 99 is the high terminal.
- R7: A rising edge of `sel_n` while `step` is high saves `wiper` into storage and raises `busy` for exactly STORE_CYCLES clocks.
- R8: A rising edge of `sel_n` while `step` is low saves nothing and leaves `busy` low.
- R9: While `busy` is high, strobe and select edges have no effect on `wiper` or on storage.
- R10: During `rst_n` low, `wiper` is loaded from storage. Unsaved adjustments are lost, and a stored value above 99 is recalled as 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset; recalls the stored position |
| nv_clear_n | input | 1 | Active-low storage initialisation to DEFAULT_POS |
| sel_n | input | 1 | Active-low select, asynchronous |
| dir_up | input | 1 | Step direction, 1 = toward high terminal, asynchronous |
| step | input | 1 | Increment strobe, acts on its falling edge, asynchronous |
| wiper | output | 7 | Current wiper position 0..99 |
| tap_sel | output | 100 | One-hot tap select, bit i = tap i |
| busy | output | 1 | High during a store interval |

## Verification
The case hardest to reach from the ports is an edge that arrives inside the store interval. To produce one, the bench first makes a store. Once `busy` is seen high, it drops select and pulses the strobe in a random direction. It then releases select and times how long `busy` stays up, so the ignored edges and the unchanged interval are checked together. The clamp on recall can only be reached when storage holds a value above 99. A second instance, built with an out-of-range default, is reset alongside the first to reach it.

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int TAPS         = 100,
  parameter int STORE_CYCLES = 1000,
  parameter int DEFAULT_POS  = 49,
  localparam int PW = $clog2(TAPS),
  localparam int CW = $clog2(STORE_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nv_clear_n,
  input  logic            sel_n,
  input  logic            dir_up,
  input  logic            step,
  output logic [PW-1:0]   wiper,
  output logic [TAPS-1:0] tap_sel,
  output logic            busy
);
  localparam logic [PW-1:0] TOP = PW'(TAPS - 1);

  logic [2:0]    sel_sh, step_sh;
  logic [1:0]    dir_sh;
  logic [PW-1:0] nv_q, recall;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_sh  <= '1;
      step_sh <= '0;
      dir_sh  <= '0;
    end else begin
      sel_sh  <= {sel_sh[1:0], sel_n};
      step_sh <= {step_sh[1:0], step};
      dir_sh  <= {dir_sh[0], dir_up};
    end
  end

  wire idle      = (busy_cnt == '0);
  wire step_fall = step_sh[2] & ~step_sh[1];
  wire sel_rise  = ~sel_sh[2] & sel_sh[1];
  wire do_step   = idle & step_fall & ~sel_sh[1];
  wire do_store  = idle & sel_rise & step_sh[1];

  assign recall = (nv_q > TOP) ? TOP : nv_q;

  always_ff @(posedge clk) begin
    if (!nv_clear_n)
      nv_q <= PW'(DEFAULT_POS);
    else if (do_store)
      nv_q <= wiper;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      wiper <= recall;
    else if (do_step) begin
      if (dir_sh[1])
        wiper <= (wiper == TOP) ? wiper : wiper + 1'b1;
      else
        wiper <= (wiper == '0) ? wiper : wiper - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (do_store)
      busy_cnt <= CW'(STORE_CYCLES);
    else if (!idle)
      busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy    = ~idle;
  assign tap_sel = TAPS'(1) << wiper;
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int TAPS = 100,
  parameter int PW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PW-1:0]   wiper,
  input logic [TAPS-1:0] tap_sel,
  input logic            busy,
  input logic [PW-1:0]   stored
);
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wiper <= PW'(TAPS - 1));

  a_r6_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper]);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (wiper == $past(wiper) || wiper == $past(wiper) + 1'b1 ||
                      wiper + 1'b1 == $past(wiper)));

  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wiper));

  a_r7_store_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (stored == wiper));
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.TAPS(TAPS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wiper(wiper), .tap_sel(tap_sel),
  .busy(busy), .stored(nv_q)
);

// File: tb/wiper_ctrl_test.sv
module wiper_ctrl_test;
  localparam int SC = 200;

  logic clk = 0, rst_n = 0, nv_clear_n = 0, sel_n = 1, dir_up = 0, step = 0;
  logic [6:0]  wiper, wiper_c;
  logic [99:0] tap_sel, tap_c;
  logic        busy, busy_c;
  int checks = 0, errors = 0, exp_pos, exp_nv, cyc_n = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc_n++;

  wiper_ctrl #(.STORE_CYCLES(SC)) uut (
    .clk(clk), .rst_n(rst_n), .nv_clear_n(nv_clear_n), .sel_n(sel_n),
    .dir_up(dir_up), .step(step), .wiper(wiper), .tap_sel(tap_sel), .busy(busy));

  wiper_ctrl #(.STORE_CYCLES(SC), .DEFAULT_POS(120)) uut_clamp (
    .clk(clk), .rst_n(rst_n), .nv_clear_n(nv_clear_n), .sel_n(1'b1),
    .dir_up(1'b0), .step(1'b0), .wiper(wiper_c), .tap_sel(tap_c), .busy(busy_c));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int model_step(int p, bit up);
    if (up) return (p == 99) ? 99 : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  task automatic check_state(string req);
    chk(req, int'(wiper), exp_pos);
    chk({req, " R6 tap"}, int'(tap_sel == (100'(1) << exp_pos)), 1);
  endtask

  task automatic pulse(bit up);
    dir_up = up; cyc(4);
    step = 1; cyc(4);
    step = 0; cyc(5);
  endtask

  task automatic select_on();
    sel_n = 0; cyc(4);
  endtask

  task automatic exit_nostore();
    sel_n = 1; cyc(5);
    chk("R8 no busy", int'(busy), 0);
  endtask

  task automatic exit_store(bit poke);
    int w = 0, t0;
    step = 1; cyc(4);
    sel_n = 1;
    while (!busy && w < 10) begin cyc(1); w++; end
    t0 = cyc_n;
    chk("R7 busy raised", int'(busy), 1);
    if (poke) begin
      sel_n = 0; cyc(4);
      pulse(1'($urandom_range(0, 1)));
      check_state("R9 edge while busy");
      sel_n = 1; cyc(4);
    end
    w = 0;
    while (busy && w < SC + 20) begin cyc(1); w++; end
    chk("R7 busy length", cyc_n - t0, SC);
    step = 0; cyc(4);
    exp_nv = exp_pos;
  endtask

  task automatic power_cycle();
    rst_n = 0; cyc(3);
    rst_n = 1; cyc(2);
    exp_pos = exp_nv;
    check_state("R10 recall");
  endtask

  initial begin
    void'($urandom(32'd7341));
    cyc(4); nv_clear_n = 1; cyc(3); rst_n = 1; cyc(2);
    exp_nv = 49; exp_pos = 49;
    check_state("R1 reset position");
    chk("R1 busy at reset", int'(busy), 0);
    chk("R10 clamp on recall", int'(wiper_c), 99);

    select_on();
    pulse(1); exp_pos = 50; check_state("R2 single up");
    pulse(0); exp_pos = 49; check_state("R3 single down");
    for (int i = 0; i < 55; i++) begin pulse(1); exp_pos = model_step(exp_pos, 1); end
    check_state("R4 saturate high");
    for (int i = 0; i < 105; i++) begin pulse(0); exp_pos = model_step(exp_pos, 0); end
    check_state("R4 saturate low");
    for (int i = 0; i < 10; i++) begin pulse(1); exp_pos = model_step(exp_pos, 1); end
    check_state("R2 count up");
    exit_store(0);
    select_on();
    for (int i = 0; i < 3; i++) begin pulse(1); exp_pos = model_step(exp_pos, 1); end
    exit_nostore();
    power_cycle();
    for (int i = 0; i < 3; i++) pulse(1'($urandom_range(0, 1)));
    check_state("R5 deselected strobes");
    select_on();
    pulse(0); exp_pos = model_step(exp_pos, 0);
    exit_store(1);
    power_cycle();

    for (int it = 0; it < 150; it++) begin
      int op = $urandom_range(0, 9);
      if (op <= 5) begin
        select_on();
        for (int k = 0, n = $urandom_range(1, 8); k < n; k++) begin
          bit up = 1'($urandom_range(0, 1));
          pulse(up); exp_pos = model_step(exp_pos, up);
        end
        check_state("R2/R3 random steps");
        if (op == 5) exit_store(0); else exit_nostore();
      end else if (op == 6) begin
        for (int k = 0; k < 2; k++) pulse(1'($urandom_range(0, 1)));
        check_state("R5 deselected strobes");
      end else if (op == 7) begin
        select_on();
        exit_store(1);
      end else begin
        power_cycle();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule